// File: doc/BRIEF.md
# Set-Associative TLB Command Engine

This block holds the joint translation array of a memory management unit and carries out the maintenance commands that software issues against it. Software loads three working registers (an entry's tag word, its data word, and a linear slot number) through a single register write port. A write to the command register then starts one of six operations. The operations are: a content probe, free-slot selection, a store with or without a micro-TLB flush, a load of a stored entry, and a bare micro-TLB flush. Results appear in the working registers, which are always visible on output ports.

The array holds `SETS` by `WAYS` entries. A linear slot number is `set * WAYS + way`, so consecutive numbers step through the ways of one set before the next set begins. The set of a tag word is taken from the low bits of its virtual page number. Every command runs through a three-state machine: `ST_IDLE`, then `ST_LOOK`, then `ST_COMMIT`, then back to `ST_IDLE`. The transition IDLE→LOOK is taken on a command write. LOOK→COMMIT and COMMIT→IDLE are unconditional. In LOOK the engine compares the target set and picks a slot. In COMMIT it updates the array, the working registers and the round-robin pointers, and it drives the micro-TLB invalidate pulse.

Tag word layout: bits [7:0] hold the address-space id, bit 8 the global flag, bit 9 the present flag, and bits [31:13] the virtual page number. Slot register layout: the low `log2(SETS*WAYS)` bits hold the slot, bit 31 is the lookup-error flag and bit 30 is the duplicate flag. Register select codes: 0 = tag, 1 = data, 2 = slot, 3 = command. Command codes: 1 probe, 2 get-free-slot, 3 store with flush, 4 store without flush, 5 load, 6 flush only; 0 and 7 do nothing.

Top module: `tlb_cmd_engine`

## Requirements
- R1: A probe hit on the entry at set s, way w reports slot number s*WAYS+w (with 4 ways, set 2 way 3 reports 11).
- R2: A probe that matches exactly one way loads the slot register with that location and both flag bits (31, 30) clear.
- R3: A probe that matches no way loads the slot register with 0x80000000 (bit 31 set, slot 0).
- R4: A probe that matches two or more ways of the set loads 0xC0000000 (bits 31 and 30 set). Duplicates are accepted without complaint when they are stored.
- R5: An entry matches when its present bit is set, its page number equals the key's, and either its global bit is set or its id equals the key's id. An entry whose present bit is clear never matches.
- R6: Get-free-slot places in the slot register the lowest-numbered way of the key's set whose present bit is clear.
- R7: When every way of that set is present, get-free-slot returns the set's round-robin way. The pointer starts at way 0 after reset and advances by one each time it is used.
- R8: Store with flush (code 3) writes the tag and data registers into the slot named by the slot register and raises `utlb_inv` for exactly one cycle. Store without flush (code 4) writes the same way with no pulse. Storing all-zero words erases an entry.
- R9: Load (code 5) copies the tag and data words of the slot named by the slot register into the tag and data registers.
- R10: Flush-only (code 6) raises `utlb_inv` for one cycle and leaves the array unchanged.
- R11: `busy` is high for exactly two cycles after a command write. Register and command writes made while `busy` is high are ignored.
- R12: After reset, all registers read zero, `busy` and `utlb_inv` are low, and every entry is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 tag, 1 data, 2 slot, 3 command |
| reg_wdata | input | 32 | Register write data (command code in bits [2:0]) |
| pd0_q | output | 32 | Tag working register |
| pd1_q | output | 32 | Data working register |
| index_q | output | 32 | Slot working register with error flags |
| busy | output | 1 | Command in progress |
| utlb_inv | output | 1 | One-cycle micro-TLB invalidate pulse |

## Verification
The bench places two identical tags in different ways of one set. A design that stopped at the first hit would return a clean slot instead of the duplicate code. It probes a global entry under an unrelated id and an absent entry under its own id; mixing up the global or present terms flips one of those results. It fills a set completely and asks for a free slot twice, which exposes a pointer that never advances or is not held per set. It also writes the data register during a running command, which a design without the busy lockout would accept.

// File: rtl/tlb_eng_pkg.sv
package tlb_eng_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_PROBE    = 3'd1,
        OP_GETIDX   = 3'd2,
        OP_WRITE    = 3'd3,
        OP_WRITE_NI = 3'd4,
        OP_READ     = 3'd5,
        OP_UINV     = 3'd6,
        OP_RSV      = 3'd7
    } tlb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOK   = 2'd1,
        ST_COMMIT = 2'd2
    } tlb_st_e;

    localparam int ASID_W      = 8;
    localparam int GLOBAL_BIT  = 8;
    localparam int PRESENT_BIT = 9;
    localparam int VPN_LSB     = 13;
    localparam int ERR_BIT     = 31;
    localparam int DUP_BIT     = 30;

    localparam logic [1:0] SEL_TAG  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_SLOT = 2'd2;
    localparam logic [1:0] SEL_CMD  = 2'd3;

endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_eng_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0][31:0] way_tag,
    input  logic [31:0]           key,
    output logic [WAYS-1:0]       hit
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic page_eq;
        logic id_ok;
        assign page_eq = (way_tag[w][31:VPN_LSB] == key[31:VPN_LSB]);
        assign id_ok   = way_tag[w][GLOBAL_BIT] ||
                         (way_tag[w][ASID_W-1:0] == key[ASID_W-1:0]);
        assign hit[w]  = way_tag[w][PRESENT_BIT] && page_eq && id_ok;
    end
endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
    parameter int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  present,
    input  logic [WAY_W-1:0] rr_way,
    output logic [WAY_W-1:0] way,
    output logic             use_rr
);
    always_comb begin
        use_rr = &present;
        way    = rr_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!present[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tlb_cmd_engine.sv
module tlb_cmd_engine
    import tlb_eng_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] pd0_q,
    output logic [31:0] pd1_q,
    output logic [31:0] index_q,
    output logic        busy,
    output logic        utlb_inv
);
    localparam int SET_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int IDX_W   = SET_W + WAY_W;
    localparam int ENTRIES = SETS * WAYS;
    localparam logic [31:0] MISS_CODE = 32'h1 << ERR_BIT;
    localparam logic [31:0] DUP_CODE  = (32'h1 << ERR_BIT) | (32'h1 << DUP_BIT);

    tlb_st_e  state, state_nx;
    tlb_op_e  op_q;

    logic [31:0] ent_tag  [ENTRIES];
    logic [31:0] ent_data [ENTRIES];
    logic [WAY_W-1:0] rr_ptr [SETS];

    logic [SET_W-1:0]        key_set, set_r;
    logic [WAYS-1:0][31:0]   set_tag;
    logic [WAYS-1:0]         set_present, hit, hit_r;
    logic [WAY_W-1:0]        pick_way, pick_way_r, hit_way;
    logic                    pick_rr, pick_rr_r;
    logic [IDX_W-1:0]        slot;
    logic                    start, is_store;

    assign key_set  = pd0_q[VPN_LSB +: SET_W];
    assign slot     = index_q[IDX_W-1:0];
    assign start    = reg_we && (reg_sel == SEL_CMD) && (state == ST_IDLE);
    assign is_store = (op_q == OP_WRITE) || (op_q == OP_WRITE_NI);

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tag[w]     = ent_tag[{key_set, WAY_W'(w)}];
            set_present[w] = set_tag[w][PRESENT_BIT];
        end
    end

    tlb_way_match #(.WAYS(WAYS)) u_match (
        .way_tag (set_tag),
        .key     (pd0_q),
        .hit     (hit)
    );

    tlb_slot_pick #(.WAYS(WAYS)) u_pick (
        .present (set_present),
        .rr_way  (rr_ptr[key_set]),
        .way     (pick_way),
        .use_rr  (pick_rr)
    );

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_r[w]) hit_way = WAY_W'(w);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_LOOK;
            ST_LOOK:   state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        utlb_inv = (state == ST_COMMIT) && ((op_q == OP_WRITE) || (op_q == OP_UINV));
    end

    // working registers and lookup pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd0_q      <= '0;
            pd1_q      <= '0;
            index_q    <= '0;
            op_q       <= OP_NOP;
            hit_r      <= '0;
            set_r      <= '0;
            pick_way_r <= '0;
            pick_rr_r  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (reg_we) begin
                        unique case (reg_sel)
                            SEL_TAG:  pd0_q   <= reg_wdata;
                            SEL_DATA: pd1_q   <= reg_wdata;
                            SEL_SLOT: index_q <= reg_wdata;
                            SEL_CMD:  op_q    <= tlb_op_e'(reg_wdata[2:0]);
                            default:  ;
                        endcase
                    end
                end
                ST_LOOK: begin
                    hit_r      <= hit;
                    set_r      <= key_set;
                    pick_way_r <= pick_way;
                    pick_rr_r  <= pick_rr;
                end
                ST_COMMIT: begin
                    unique case (op_q)
                        OP_PROBE: begin
                            if (hit_r == '0)                index_q <= MISS_CODE;
                            else if ($countones(hit_r) == 1) index_q <= 32'({set_r, hit_way});
                            else                             index_q <= DUP_CODE;
                        end
                        OP_GETIDX: index_q <= 32'({set_r, pick_way_r});
                        OP_READ: begin
                            pd0_q <= ent_tag[slot];
                            pd1_q <= ent_data[slot];
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // entry array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_tag[i]  <= '0;
                ent_data[i] <= '0;
            end
        end else if ((state == ST_COMMIT) && is_store) begin
            ent_tag[slot]  <= pd0_q;
            ent_data[slot] <= pd1_q;
        end
    end

    // per-set round-robin victim pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_ptr[s] <= '0;
        end else if ((state == ST_COMMIT) && (op_q == OP_GETIDX) && pick_rr_r) begin
            rr_ptr[set_r] <= rr_ptr[set_r] + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_cmd_engine_chk.sv
module tlb_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        utlb_inv,
    input logic [31:0] index_q,
    input logic [31:0] pd1_q
);
    // R11
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 !busy);

    // R11
    pd1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> $stable(pd1_q));

    // R8
    inv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        utlb_inv |=> !utlb_inv);

    // R10
    inv_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        utlb_inv |-> busy);

    // R4
    dup_has_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        index_q[30] |-> index_q[31]);
endmodule

bind tlb_cmd_engine tlb_cmd_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .utlb_inv (utlb_inv),
    .index_q  (index_q),
    .pd1_q    (pd1_q)
);

// File: tb/test_tlb_cmd_engine.sv
module test_tlb_cmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] pd0_q, pd1_q, index_q;
    logic        busy, utlb_inv;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    tlb_cmd_engine #(.SETS(128), .WAYS(4)) i_tlb_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .pd0_q(pd0_q), .pd1_q(pd1_q),
        .index_q(index_q), .busy(busy), .utlb_inv(utlb_inv)
    );

    function automatic logic [31:0] tag(input logic [18:0] vpn, input logic [7:0] id,
                                        input logic g, input logic v);
        return {vpn, 3'b000, v, g, id};
    endfunction

    localparam logic [31:0] TAG_A = {19'h00102, 3'b0, 1'b1, 1'b0, 8'h05};
    localparam logic [31:0] TAG_B = {19'h00209, 3'b0, 1'b1, 1'b1, 8'h03};
    localparam logic [31:0] TAG_C = {19'h0030C, 3'b0, 1'b0, 1'b0, 8'h01};
    localparam logic [31:0] TAG_D = {19'h00405, 3'b0, 1'b1, 1'b0, 8'h07};
    localparam logic [31:0] MISS  = 32'h8000_0000;
    localparam logic [31:0] DUP   = 32'hC000_0000;

    // probe key, expected slot register
    localparam logic [63:0] PROBES [7] = '{
        {TAG_A, 32'd11},
        {{19'h00102, 3'b0, 1'b1, 1'b0, 8'h06}, MISS},
        {{19'h00209, 3'b0, 1'b1, 1'b0, 8'h03}, 32'd36},
        {{19'h00209, 3'b0, 1'b1, 1'b0, 8'hAA}, 32'd36},
        {{19'h0030C, 3'b0, 1'b1, 1'b0, 8'h01}, MISS},
        {TAG_D, DUP},
        {{19'h00502, 3'b0, 1'b1, 1'b0, 8'h05}, MISS}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // starts a command, returns pulses and busy cycles seen
    task automatic run_cmd(input logic [2:0] op, output int pulses, output int bcyc,
                           input logic poke = 1'b0);
        pulses = 0; bcyc = 0;
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = {29'd0, op};
        @(negedge clk);
        if (poke) begin
            reg_sel = 2'd1; reg_wdata = 32'hDEAD_BEEF;
        end else reg_we = 1'b0;
        while (busy) begin
            bcyc++;
            if (utlb_inv) pulses++;
            @(negedge clk);
            reg_we = 1'b0;
        end
    endtask

    task automatic store(input logic [31:0] slot, input logic [31:0] t, input logic [31:0] d,
                         input logic [2:0] op, output int pulses);
        int bc;
        wr_reg(2'd0, t);
        wr_reg(2'd1, d);
        wr_reg(2'd2, slot);
        run_cmd(op, pulses, bc);
    endtask

    task automatic probe(input logic [31:0] key);
        int p, bc;
        wr_reg(2'd0, key);
        run_cmd(3'd1, p, bc);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R11 watchdog: actual %0d cycles expected < 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p, bc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 busy", {31'd0, busy}, 32'd0);
        check("R12 inv", {31'd0, utlb_inv}, 32'd0);
        check("R12 tag", pd0_q, 32'd0);
        check("R12 slot", index_q, 32'd0);
        probe(TAG_A);
        check("R12 empty array", index_q, MISS);

        // R8 stores: pulse with flush, none without
        store(32'd11, TAG_A, 32'h0000_A111, 3'd3, p);
        check("R8 flush pulse", p, 32'd1);
        store(32'd36, TAG_B, 32'h0000_B222, 3'd4, p);
        check("R8 no-flush store", p, 32'd0);
        store(32'd49, TAG_C, 32'h0000_C333, 3'd4, p);
        store(32'd20, TAG_D, 32'h1, 3'd4, p);
        store(32'd22, TAG_D, 32'h2, 3'd4, p);

        // R1 R2 R3 R4 R5 probe table
        for (int i = 0; i < 7; i++) begin
            probe(PROBES[i][63:32]);
            check($sformatf("R2 probe row %0d", i), index_q, PROBES[i][31:0]);
        end

        // R9 load
        wr_reg(2'd0, 32'd0);
        wr_reg(2'd1, 32'd0);
        wr_reg(2'd2, 32'd36);
        run_cmd(3'd5, p, bc);
        check("R9 load tag", pd0_q, TAG_B);
        check("R9 load data", pd1_q, 32'h0000_B222);

        // R6 first free way
        wr_reg(2'd0, TAG_A);
        run_cmd(3'd2, p, bc);
        check("R6 set2 free", index_q, 32'd8);
        wr_reg(2'd0, TAG_D);
        run_cmd(3'd2, p, bc);
        check("R6 set5 free", index_q, 32'd21);

        // R7 full set round robin
        for (int w = 0; w < 4; w++) begin
            store(32'(28 + w), tag(19'h00107 + 19'(w * 128), 8'h02, 1'b0, 1'b1), 32'h0, 3'd4, p);
        end
        wr_reg(2'd0, tag(19'h00607, 8'h02, 1'b0, 1'b1));
        run_cmd(3'd2, p, bc);
        check("R7 victim first", index_q, 32'd28);
        run_cmd(3'd2, p, bc);
        check("R7 victim advance", index_q, 32'd29);

        // R10 flush only
        run_cmd(3'd6, p, bc);
        check("R10 pulse", p, 32'd1);
        probe(TAG_A);
        check("R10 array kept", index_q, 32'd11);

        // R11 busy length and write lockout
        wr_reg(2'd1, 32'h1234_5678);
        wr_reg(2'd0, TAG_A);
        run_cmd(3'd1, p, bc, 1'b1);
        check("R11 busy cycles", bc, 32'd2);
        check("R11 write ignored", pd1_q, 32'h1234_5678);

        // R8 erase
        store(32'd11, 32'd0, 32'd0, 3'd3, p);
        probe(TAG_A);
        check("R8 erased", index_q, MISS);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule